// File: doc/BRIEF.md
# Nested Loop Instruction Sequencer

This block turns compact loop programs into one wide control word per cycle for a pipelined datapath. Several small controllers run side by side, each owning one loop nest. A controller walks a short program in which every entry pairs a control word with a repeat count. An entry means "issue this word on this many consecutive cycles". A loop body whose index conditionals have been resolved ahead of time becomes a few such entries. For example, a 16-pass inner loop with a first-pass special case and a split at pass 8 becomes a 1-cycle entry, a 7-cycle entry and an 8-cycle entry. A per-controller outer count replays the whole entry list a set number of times, which covers the enclosing loop.

Controllers coordinate through status bits. An entry can raise its controller's status bit when it issues. An entry can also be told to wait until a chosen status bit is set. While it waits, the controller issues nothing. The controllers' words are each limited to a disjoint field of the output. They are OR-ed into one combined word and registered, and that register drives every stage of the datapath at once.

Programs and outer counts are loaded through a simple write port. A per-controller start pulse launches a run. A global stall freezes every controller in place and blanks the output.

Top module: `nls_sequencer`

## Requirements
- R1: After reset `ctrl_word`, `busy` and `status` are all zero.
- R2: An entry with repeat count N (N from 1 to 255; 0 acts as 1) contributes its word on exactly N consecutive non-stalled, non-waiting cycles.
- R3: Entries run in ascending address order from entry 0. An entry whose last flag is set, or the entry at the highest address, ends one pass over the list.
- R4: The outer count register (0 acts as 1) sets how many passes run. Each later pass restarts at entry 0. After the final pass the controller's `busy` bit drops and its field returns to zero.
- R5: Controller k contributes only inside its field mask. By default it owns output bits 8k+7 down to 8k, and word bits outside that field are dropped.
- R6: `ctrl_word` is the bitwise OR of the fields of all controllers issuing in the same cycle.
- R7: An entry with the wait flag set contributes zero and makes no repeat progress until the status bit of the controller named by its wait-select field is set.
- R8: An entry with the mark flag sets its controller's `status` bit in the cycle it first issues. The bit stays set until that controller is started again, and a start clears it.
- R9: While `stall` is high, every controller keeps its position and counts, and the issue cycle yields an all-zero word. Issue resumes exactly where it stopped.
- R10: `ctrl_word` is registered. The word for an issue cycle appears after the clock edge that ends that cycle. A start applied at an edge makes the controller issue in the following cycle.
- R11: A program entry or outer count changes only on a cycle with `wr_en` high, and only for the controller picked by `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall | input | 1 | Global freeze of all controllers |
| start | input | 3 | Per-controller start pulse |
| wr_en | input | 1 | Program write strobe |
| wr_sel | input | 2 | Controller addressed by the write |
| wr_outer | input | 1 | 1: write outer count from wr_count; 0: write a program entry |
| wr_addr | input | 4 | Program entry address |
| wr_word | input | 24 | Entry control word |
| wr_count | input | 8 | Entry repeat count or outer count |
| wr_wait | input | 1 | Entry wait flag |
| wr_wsel | input | 2 | Entry wait-select: index of the status bit waited on |
| wr_mark | input | 1 | Entry mark flag (raises own status) |
| wr_last | input | 1 | Entry last flag (ends a pass) |
| ctrl_word | output | 24 | Merged, registered control plane word |
| busy | output | 3 | Controller is running |
| status | output | 3 | Sticky per-controller status bits |

## Verification
The bench targets the pass boundary, where the outer count must restart at entry 0. A design that is off by one there would drop or repeat a pass, or would replay only the last entry. A stall is placed on the cycle where an entry change is due. A design that advances during a stall would skip words or lose a repeat. A waiting controller is run against a marking controller. A design that counts repeats while it waits, or leaks its word while blocked, would show wrong words in the merged output. The bench also writes with the strobe low and restarts a controller whose status bit is set, which catches a stray write and a status bit that never clears.

// File: rtl/nls_pkg.sv
package nls_pkg;
    localparam int DEF_NCTRL = 3;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_CW    = 24;
    localparam int DEF_RW    = 8;

    function automatic int sel_bits(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/nls_ctrl.sv
module nls_ctrl #(
    parameter int CW    = nls_pkg::DEF_CW,
    parameter int RW    = nls_pkg::DEF_RW,
    parameter int DEPTH = nls_pkg::DEF_DEPTH,
    parameter int NCTRL = nls_pkg::DEF_NCTRL,
    parameter logic [CW-1:0] MASK = '1,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEL_W = nls_pkg::sel_bits(NCTRL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             start,
    input  logic             wr_en,
    input  logic             wr_outer,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CW-1:0]    wr_word,
    input  logic [RW-1:0]    wr_count,
    input  logic             wr_wait,
    input  logic [SEL_W-1:0] wr_wsel,
    input  logic             wr_mark,
    input  logic             wr_last,
    input  logic [NCTRL-1:0] status_all,
    output logic [CW-1:0]    field,
    output logic             busy,
    output logic             status
);
    typedef struct packed {
        logic [CW-1:0]    word;
        logic [RW-1:0]    count;
        logic             wait_en;
        logic [SEL_W-1:0] wsel;
        logic             mark;
        logic             last;
    } entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] pc;
        logic [RW-1:0]    rep;
        logic [RW-1:0]    outer;
        logic [RW-1:0]    ocfg;
        logic             active;
        logic             status;
    } state_t;

    entry_t prog_q [DEPTH];
    state_t st_d, st_q;
    entry_t cur;
    logic [RW:0] cnt_eff;
    logic [2**SEL_W-1:0] st_pad;
    logic go;

    always_ff @(posedge clk) begin
        if (wr_en && !wr_outer) begin
            prog_q[wr_addr] <= '{word: wr_word, count: wr_count, wait_en: wr_wait,
                                 wsel: wr_wsel, mark: wr_mark, last: wr_last};
        end
    end

    always_comb begin
        st_d    = st_q;
        field   = '0;
        cur     = prog_q[st_q.pc];
        cnt_eff = (cur.count == '0) ? (RW+1)'(1) : {1'b0, cur.count};
        st_pad  = '0;
        st_pad[NCTRL-1:0] = status_all;
        go = st_q.active && !stall && (!cur.wait_en || st_pad[cur.wsel]);

        if (wr_en && wr_outer) begin
            st_d.ocfg = wr_count;
        end

        if (start) begin
            st_d.active = 1'b1;
            st_d.pc     = '0;
            st_d.rep    = '0;
            st_d.outer  = st_q.ocfg;
            st_d.status = 1'b0;
        end else if (go) begin
            field = cur.word & MASK;
            if (cur.mark) begin
                st_d.status = 1'b1;
            end
            if ({1'b0, st_q.rep} + (RW+1)'(1) == cnt_eff) begin
                st_d.rep = '0;
                if (cur.last || st_q.pc == IDX_W'(DEPTH-1)) begin
                    if (st_q.outer > RW'(1)) begin
                        st_d.outer = st_q.outer - RW'(1);
                        st_d.pc    = '0;
                    end else begin
                        st_d.active = 1'b0;
                    end
                end else begin
                    st_d.pc = st_q.pc + IDX_W'(1);
                end
            end else begin
                st_d.rep = st_q.rep + RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ocfg <= RW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.active;
    assign status = st_q.status;

    assert_rep_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> ({1'b0, st_q.rep} < cnt_eff));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> field == '0);

    assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur.wait_en && !st_pad[cur.wsel]) |-> field == '0);

    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status && !start) |=> st_q.status);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !start) |=> ($stable(st_q.pc) && $stable(st_q.rep) && $stable(st_q.outer)));
endmodule

// File: rtl/nls_merge.sv
module nls_merge #(
    parameter int NCTRL = nls_pkg::DEF_NCTRL,
    parameter int CW    = nls_pkg::DEF_CW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCTRL*CW-1:0] fields,
    output logic [CW-1:0]       merged
);
    logic [CW-1:0] merged_d, merged_q;

    always_comb begin
        merged_d = '0;
        for (int k = 0; k < NCTRL; k++) begin
            merged_d = merged_d | fields[k*CW +: CW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) merged_q <= '0;
        else        merged_q <= merged_d;
    end

    assign merged = merged_q;
endmodule

// File: rtl/nls_sequencer.sv
module nls_sequencer #(
    parameter int NCTRL = nls_pkg::DEF_NCTRL,
    parameter int DEPTH = nls_pkg::DEF_DEPTH,
    parameter int CW    = nls_pkg::DEF_CW,
    parameter int RW    = nls_pkg::DEF_RW,
    parameter logic [NCTRL*CW-1:0] FIELD_MASKS = {24'hFF0000, 24'h00FF00, 24'h0000FF},
    localparam int IDX_W = $clog2(DEPTH),
    localparam int SEL_W = nls_pkg::sel_bits(NCTRL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [NCTRL-1:0] start,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_outer,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [CW-1:0]    wr_word,
    input  logic [RW-1:0]    wr_count,
    input  logic             wr_wait,
    input  logic [SEL_W-1:0] wr_wsel,
    input  logic             wr_mark,
    input  logic             wr_last,
    output logic [CW-1:0]    ctrl_word,
    output logic [NCTRL-1:0] busy,
    output logic [NCTRL-1:0] status
);
    logic [NCTRL*CW-1:0] fields;

    for (genvar k = 0; k < NCTRL; k++) begin : g_ctrl
        nls_ctrl #(
            .CW(CW), .RW(RW), .DEPTH(DEPTH), .NCTRL(NCTRL),
            .MASK(FIELD_MASKS[k*CW +: CW])
        ) i_ctrl (
            .clk        (clk),
            .rst_n      (rst_n),
            .stall      (stall),
            .start      (start[k]),
            .wr_en      (wr_en && (wr_sel == SEL_W'(k))),
            .wr_outer   (wr_outer),
            .wr_addr    (wr_addr),
            .wr_word    (wr_word),
            .wr_count   (wr_count),
            .wr_wait    (wr_wait),
            .wr_wsel    (wr_wsel),
            .wr_mark    (wr_mark),
            .wr_last    (wr_last),
            .status_all (status),
            .field      (fields[k*CW +: CW]),
            .busy       (busy[k]),
            .status     (status[k])
        );
    end

    nls_merge #(.NCTRL(NCTRL), .CW(CW)) i_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .fields (fields),
        .merged (ctrl_word)
    );

    assert_stall_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ctrl_word == '0);

    assert_idle_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy == '0) |=> ctrl_word == '0);
endmodule

// File: tb/test_nls_sequencer.sv
module test_nls_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall = 1'b0;
    logic [2:0]  start = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic        wr_outer = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [23:0] wr_word = '0;
    logic [7:0]  wr_count = '0;
    logic        wr_wait = 1'b0;
    logic [1:0]  wr_wsel = '0;
    logic        wr_mark = 1'b0;
    logic        wr_last = 1'b0;
    logic [23:0] ctrl_word;
    logic [2:0]  busy;
    logic [2:0]  status;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nls_sequencer i_nls_sequencer (
        .clk(clk), .rst_n(rst_n), .stall(stall), .start(start),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_outer(wr_outer), .wr_addr(wr_addr),
        .wr_word(wr_word), .wr_count(wr_count), .wr_wait(wr_wait), .wr_wsel(wr_wsel),
        .wr_mark(wr_mark), .wr_last(wr_last),
        .ctrl_word(ctrl_word), .busy(busy), .status(status)
    );

    typedef struct packed {
        logic [2:0]  st;
        logic        stl;
        logic [23:0] exp;
    } vec_t;

    // rows 0-16: controller 2 alone, outer 2, stall on rows 4-5 (R2 R3 R4 R5 R9 R10)
    // rows 17-24: controllers 0 and 1 with handshake (R6 R7 R8 R10)
    localparam vec_t VECS [25] = '{
        '{3'b100, 1'b0, 24'h000000},
        '{3'b000, 1'b0, 24'h110000},
        '{3'b000, 1'b0, 24'h220000},
        '{3'b000, 1'b0, 24'h220000},
        '{3'b000, 1'b1, 24'h000000},
        '{3'b000, 1'b1, 24'h000000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h110000},
        '{3'b000, 1'b0, 24'h220000},
        '{3'b000, 1'b0, 24'h220000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h330000},
        '{3'b000, 1'b0, 24'h000000},
        '{3'b000, 1'b0, 24'h000000},
        '{3'b011, 1'b0, 24'h000000},
        '{3'b000, 1'b0, 24'h000301},
        '{3'b000, 1'b0, 24'h000001},
        '{3'b000, 1'b0, 24'h000001},
        '{3'b000, 1'b0, 24'h000002},
        '{3'b000, 1'b0, 24'h000500},
        '{3'b000, 1'b0, 24'h000500},
        '{3'b000, 1'b0, 24'h000000}
    };

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_entry(logic [1:0] c, logic [3:0] a, logic [23:0] w, logic [7:0] n,
                             logic wt, logic [1:0] ws, logic mk, logic lst);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = c; wr_outer = 1'b0; wr_addr = a; wr_word = w;
        wr_count = n; wr_wait = wt; wr_wsel = ws; wr_mark = mk; wr_last = lst;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_outer(logic [1:0] c, logic [7:0] n);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = c; wr_outer = 1'b1; wr_count = n;
        @(negedge clk);
        wr_en = 1'b0; wr_outer = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ctrl_word", ctrl_word, 24'h0);
        check("R1 busy", {21'h0, busy}, 24'h0);
        check("R1 status", {21'h0, status}, 24'h0);
        rst_n = 1'b1;

        put_entry(2'd2, 4'd0, 24'h11ABCD, 8'd1, 1'b0, 2'd0, 1'b0, 1'b0);
        put_entry(2'd2, 4'd1, 24'h220000, 8'd2, 1'b0, 2'd0, 1'b0, 1'b0);
        put_entry(2'd2, 4'd2, 24'h330000, 8'd3, 1'b0, 2'd0, 1'b0, 1'b1);
        put_outer(2'd2, 8'd2);
        put_entry(2'd0, 4'd0, 24'h000001, 8'd3, 1'b0, 2'd0, 1'b0, 1'b0);
        put_entry(2'd0, 4'd1, 24'h000002, 8'd1, 1'b0, 2'd0, 1'b1, 1'b1);
        put_outer(2'd0, 8'd1);
        put_entry(2'd1, 4'd0, 24'h000300, 8'd1, 1'b0, 2'd0, 1'b0, 1'b0);
        put_entry(2'd1, 4'd1, 24'h000500, 8'd2, 1'b1, 2'd0, 1'b0, 1'b1);
        put_outer(2'd1, 8'd1);

        // R11: fields driven with the strobe low must not land in controller 2 entry 0
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd2; wr_outer = 1'b0; wr_addr = 4'd0;
        wr_word = 24'h990000; wr_count = 8'd5; wr_last = 1'b1;
        @(negedge clk);
        wr_sel = 2'd0; wr_outer = 1'b1; wr_count = 8'd9;
        @(negedge clk);
        wr_outer = 1'b0;

        foreach (VECS[i]) begin
            @(negedge clk);
            start = VECS[i].st;
            stall = VECS[i].stl;
            @(posedge clk);
            #1;
            if (i <= 3) check("R11 R5 R2 R10 row", ctrl_word, VECS[i].exp);
            else if (i <= 16) check("R2 R3 R4 R9 row", ctrl_word, VECS[i].exp);
            else check("R6 R7 R8 row", ctrl_word, VECS[i].exp);
            if (i == 16) check("R4 busy after passes", {21'h0, busy}, 24'h0);
        end
        start = '0;

        check("R4 busy idle", {21'h0, busy}, 24'h0);
        check("R8 status marked", {21'h0, status}, 24'h000001);

        // R8: a restart clears the mark, even while stalled
        @(negedge clk);
        start = 3'b001; stall = 1'b1;
        @(posedge clk);
        #1;
        check("R8 status cleared", {21'h0, status}, 24'h0);
        check("R9 stalled output", ctrl_word, 24'h0);
        @(negedge clk);
        start = '0;
        @(posedge clk);
        #1;
        check("R9 held busy", {21'h0, busy}, 24'h000001);
        check("R9 held output", ctrl_word, 24'h0);
        @(negedge clk);
        stall = 1'b0;
        @(posedge clk);
        #1;
        check("R9 resume word", ctrl_word, 24'h000001);
        repeat (5) @(posedge clk);
        #1;
        check("R4 second run idle", {21'h0, busy}, 24'h0);
        check("R8 status set again", {21'h0, status}, 24'h000001);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule